// File: doc/BRIEF.md
# Multiphase PWM Phase-Zero Generator

This block sets the switching cycle for the two PWM channels of one controller in a power supply that spreads its phases over one or two controllers. A counter runs from zero to a programmable period minus one. Each channel gets a one-cycle start pulse when the counter reaches that channel's offset. The offset is a fixed fraction of the period, and it depends on how many phases the system has and on whether this controller leads the pair or follows it.

A source selection decides how the cycle is kept in step. The block can run free on its own clock. It can restart on every rising edge of an external synchronization clock while still placing the channels itself. Or it can restart on every rising edge of an external phase-zero reference that two controllers share. A synchronization enable must be high before any external signal is used. A following controller always takes its phase zero from the shared reference and is limited to the phase counts that span two controllers. A leading controller that runs from its own clock with synchronization enabled drives a synchronization pulse at the start of each cycle for its partner.

All inputs are synchronous to `clk`. The analog stages and the configuration registers sit outside this block.

Top module: `mphase_gen`

## Requirements
- R1: While `rst_n` is low, `ch_start_o` and `sync_o` are low and the cycle counter is held at zero.
- R2: The counter steps once per clock through 0 to N-1, where N is `period_i` (at least 4), and then returns to 0. Channel k raises `ch_start_o[k]` for exactly the one cycle in which the counter equals its offset. The pulse is registered, so it is visible in the same cycle in which the counter shows that value.
- R3: With `phase_cnt_i` = 00 (independent channels), both channel offsets are 0.
- R4: With `phase_cnt_i` = 01 (two phases in one controller), channel 0 is at offset 0 and channel 1 is at floor(N/2).
- R5: With `phase_cnt_i` = 10 (three phases over two controllers), a leader places its channels at 0 and floor(N/3). A follower places channel 0 at floor(2N/3) and channel 1 at 0, so the follower's single-phase rail lines up with the leader's channel 0.
- R6: With `phase_cnt_i` = 11 (four phases over two controllers), a leader places its channels at 0 and floor(N/2). A follower places them at floor(N/4) and floor(N/2)+floor(N/4).
- R7: With `sync_en_i` = 0, both `sync_i` and `phdet_i` are ignored and the counter runs free.
- R8: With `sync_en_i` = 1, `follower_i` = 0 and `sync_mode_i` = 01, a rising edge of `sync_i` makes the counter read 0 in the next cycle, so offset-0 channels pulse in that cycle. In this mode `phdet_i` is ignored.
- R9: With `sync_en_i` = 1 and `sync_mode_i` = 10 or 11, a rising edge of `phdet_i` makes the counter read 0 in the next cycle. In these modes `sync_i` is ignored.
- R10: With `follower_i` = 1, the upper bit of the phase count is always treated as 1. When `sync_en_i` = 1, the source is treated as 11 whatever `sync_mode_i` holds.
- R11: `sync_o` pulses for one cycle while the counter reads 0, and only when the previous cycle had `sync_en_i` = 1, `follower_i` = 0 and `sync_mode_i` = 00.
- R12: If `period_i` is lowered while the counter is at or above the new N-1, the counter reads 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CW (16) | Cycle length N in clock ticks |
| sync_mode_i | input | 2 | Source: 00 own clock, 01 external clock, 1x external phase zero |
| phase_cnt_i | input | 2 | Phase count: 00 independent, 01 two, 10 three, 11 four |
| sync_en_i | input | 1 | Allows the external signals to be used |
| follower_i | input | 1 | 1 when this controller follows its partner |
| sync_i | input | 1 | External synchronization clock |
| phdet_i | input | 1 | Shared external phase-zero reference |
| ch_start_o | output | 2 | One-cycle start pulse for each channel |
| sync_o | output | 1 | Synchronization pulse driven by a self-clocked leader |

## Verification
The assertions assume that `period_i` is at least 4 and that every input is already synchronous to `clk`. Under those assumptions a rising edge is simply a high level that follows a low level one cycle earlier. The stimulus picks periods between 4 and 40 and changes every input only at the falling clock edge. Edges on `sync_i` and `phdet_i` are made by toggling those inputs no faster than one level per cycle.

// File: rtl/mpg_pkg.sv
`timescale 1ns/1ps
package mpg_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    SRC_OWN     = 2'b00,
    SRC_EXT_CLK = 2'b01,
    SRC_EXT_PZA = 2'b10,
    SRC_EXT_PZB = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    PH_INDEP = 2'b00,
    PH_TWO   = 2'b01,
    PH_THREE = 2'b10,
    PH_FOUR  = 2'b11
  } ph_count_e;

  typedef struct packed {
    src_mode_e src;
    ph_count_e ph;
    logic      follower;
    logic      drive_sync;
  } cfg_t;
endpackage

// File: rtl/mpg_cfg.sv
`timescale 1ns/1ps
// Resolves the raw configuration pins into the effective operating mode.
module mpg_cfg
  import mpg_pkg::*;
(
  input  logic [1:0] sync_mode_i,
  input  logic [1:0] phase_cnt_i,
  input  logic       sync_en_i,
  input  logic       follower_i,
  output cfg_t       cfg_o
);
  always_comb begin
    cfg_o = '0;
    cfg_o.follower = follower_i;
    // External signals are used only when synchronization is enabled.
    if (!sync_en_i)
      cfg_o.src = SRC_OWN;
    else if (follower_i)
      cfg_o.src = SRC_EXT_PZB;
    else
      cfg_o.src = src_mode_e'(sync_mode_i);
    // A follower can only take part in a two-controller arrangement.
    if (follower_i)
      cfg_o.ph = ph_count_e'({1'b1, phase_cnt_i[0]});
    else
      cfg_o.ph = ph_count_e'(phase_cnt_i);
    cfg_o.drive_sync = sync_en_i && !follower_i && (sync_mode_i == 2'b00);
  end
endmodule

// File: rtl/mpg_offsets.sv
`timescale 1ns/1ps
// Per-channel firing offsets as fractions of the programmed period.
module mpg_offsets
  import mpg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0]           period_i,
  input  cfg_t                    cfg_i,
  output logic [NCH-1:0][CW-1:0]  off_o
);
  localparam int EW = CW + 2;

  logic [EW-1:0] n_ext;
  logic [CW-1:0] half, quarter, three_q, third, two_third;

  always_comb begin
    n_ext     = {2'b00, period_i};
    half      = period_i >> 1;
    quarter   = period_i >> 2;
    three_q   = half + quarter;
    third     = CW'(n_ext / EW'(3));
    two_third = CW'((n_ext << 1) / EW'(3));
  end

  always_comb begin
    off_o = '0;
    unique case (cfg_i.ph)
      PH_INDEP: begin
        off_o[0] = '0;
        off_o[1] = '0;
      end
      PH_TWO: begin
        off_o[0] = '0;
        off_o[1] = half;
      end
      PH_THREE: begin
        if (cfg_i.follower) begin
          off_o[0] = two_third;
          off_o[1] = '0;
        end else begin
          off_o[0] = '0;
          off_o[1] = third;
        end
      end
      PH_FOUR: begin
        if (cfg_i.follower) begin
          off_o[0] = quarter;
          off_o[1] = three_q;
        end else begin
          off_o[0] = '0;
          off_o[1] = half;
        end
      end
      default: off_o = '0;
    endcase
  end
endmodule

// File: rtl/mpg_restart.sv
`timescale 1ns/1ps
// Edge detection on the external references and restart selection.
module mpg_restart
  import mpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_mode_e src_i,
  input  logic      sync_i,
  input  logic      phdet_i,
  output logic      restart_o
);
  localparam int NREF = 2;
  localparam int IX_SYNC = 0;
  localparam int IX_PZ   = 1;

  logic [NREF-1:0] raw;
  logic [NREF-1:0] prev_q;
  logic [NREF-1:0] rise;

  assign raw = {phdet_i, sync_i};

  for (genvar g = 0; g < NREF; g++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= raw[g];
    end
    assign rise[g] = raw[g] & ~prev_q[g];
  end

  always_comb begin
    restart_o = 1'b0;
    unique case (src_i)
      SRC_EXT_CLK:              restart_o = rise[IX_SYNC];
      SRC_EXT_PZA, SRC_EXT_PZB: restart_o = rise[IX_PZ];
      default:                  restart_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mpg_counter.sv
`timescale 1ns/1ps
// Cycle counter with wrap at period-1 and external restart.
module mpg_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = period_i - CW'(1);

  always_comb begin
    if (restart_i)          cnt_nxt_o = '0;
    else if (cnt_q >= last) cnt_nxt_o = '0;
    else                    cnt_nxt_o = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mpg_pulse.sv
`timescale 1ns/1ps
// Registered start pulses, aligned with the counter value that matches.
module mpg_pulse
  import mpg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CW-1:0]           cnt_nxt_i,
  input  logic [NCH-1:0][CW-1:0]  off_i,
  input  logic                    drive_sync_i,
  output logic [NCH-1:0]          start_o,
  output logic                    sync_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_o[k] <= 1'b0;
      else        start_o[k] <= (cnt_nxt_i == off_i[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_o <= 1'b0;
    else        sync_o <= drive_sync_i && (cnt_nxt_i == '0);
  end
endmodule

// File: rtl/mphase_gen.sv
`timescale 1ns/1ps
module mphase_gen
  import mpg_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [1:0]    sync_mode_i,
  input  logic [1:0]    phase_cnt_i,
  input  logic          sync_en_i,
  input  logic          follower_i,
  input  logic          sync_i,
  input  logic          phdet_i,
  output logic [1:0]    ch_start_o,
  output logic          sync_o
);
  cfg_t                   cfg;
  logic [NCH-1:0][CW-1:0] off;
  logic                   restart;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          cnt_nxt;
  logic [NCH-1:0]         start;

  mpg_cfg u_cfg (
    .sync_mode_i (sync_mode_i),
    .phase_cnt_i (phase_cnt_i),
    .sync_en_i   (sync_en_i),
    .follower_i  (follower_i),
    .cfg_o       (cfg)
  );

  mpg_offsets #(.CW(CW)) u_off (
    .period_i (period_i),
    .cfg_i    (cfg),
    .off_o    (off)
  );

  mpg_restart u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (cfg.src),
    .sync_i    (sync_i),
    .phdet_i   (phdet_i),
    .restart_o (restart)
  );

  mpg_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_i  (period_i),
    .restart_i (restart),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  mpg_pulse #(.CW(CW)) u_pulse (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_nxt_i    (cnt_nxt),
    .off_i        (off),
    .drive_sync_i (cfg.drive_sync),
    .start_o      (start),
    .sync_o       (sync_o)
  );

  assign ch_start_o = start;
endmodule

// File: rtl/mphase_gen_chk.sv
`timescale 1ns/1ps
module mphase_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] period_i,
  input logic [1:0]    sync_mode_i,
  input logic          sync_en_i,
  input logic          follower_i,
  input logic          sync_i,
  input logic          phdet_i,
  input logic [1:0]    ch_start_o,
  input logic          sync_o,
  input logic [CW-1:0] cnt_q
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (ch_start_o == 2'b00 && !sync_o && cnt_q == '0));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= period_i - CW'(1)) |=> (cnt_q == '0));

  p_free_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en_i && cnt_q < period_i - CW'(1)) |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));

  p_sync_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en_i && !follower_i && sync_mode_i == 2'b01 && sync_i && !$past(sync_i))
    |=> (cnt_q == '0));

  p_pz_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en_i && (follower_i || sync_mode_i[1]) && phdet_i && !$past(phdet_i))
    |=> (cnt_q == '0));

  p_sync_at_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> (cnt_q == '0));

  p_sync_leader_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> $past(sync_en_i && !follower_i && sync_mode_i == 2'b00));
endmodule

bind mphase_gen mphase_gen_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .period_i    (period_i),
  .sync_mode_i (sync_mode_i),
  .sync_en_i   (sync_en_i),
  .follower_i  (follower_i),
  .sync_i      (sync_i),
  .phdet_i     (phdet_i),
  .ch_start_o  (ch_start_o),
  .sync_o      (sync_o),
  .cnt_q       (cnt_q)
);

// File: tb/mphase_gen_tb.sv
`timescale 1ns/1ps
module mphase_gen_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] period;
  logic [1:0]    smode, pcnt;
  logic          sen, fol, syn, phd;
  logic [1:0]    ch;
  logic          so;

  always #5 clk = ~clk;

  mphase_gen #(.CW(CW)) u_dut (
    .clk (clk), .rst_n (rst_n), .period_i (period), .sync_mode_i (smode),
    .phase_cnt_i (pcnt), .sync_en_i (sen), .follower_i (fol), .sync_i (syn),
    .phdet_i (phd), .ch_start_o (ch), .sync_o (so)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  logic  cmp_on = 1'b0;

  task automatic chk(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Reference offsets from the requirements (R3..R6, R10).
  function automatic int f_off(int k, int n, logic [1:0] ph, logic fl);
    logic [1:0] e;
    e = fl ? {1'b1, ph[0]} : ph;
    case (e)
      2'b00: return 0;
      2'b01: return (k == 0) ? 0 : n / 2;
      2'b10: return fl ? ((k == 0) ? (2 * n) / 3 : 0) : ((k == 0) ? 0 : n / 3);
      default: return fl ? ((k == 0) ? n / 4 : n / 2 + n / 4) : ((k == 0) ? 0 : n / 2);
    endcase
  endfunction

  function automatic logic [1:0] f_src(logic en, logic fl, logic [1:0] m);
    if (!en) return 2'b00;
    if (fl) return 2'b11;
    return m;
  endfunction

  int         m_cnt;
  logic       m_sp, m_pp, m_so;
  logic [1:0] m_ch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_sp <= 1'b0; m_pp <= 1'b0; m_ch <= 2'b00; m_so <= 1'b0;
    end else begin : mdl
      int n; int nx; logic [1:0] src; logic rs;
      n   = int'(period);
      src = f_src(sen, fol, smode);
      rs  = (src == 2'b01 && syn && !m_sp) || (src[1] && phd && !m_pp);
      if (rs) nx = 0;
      else if (m_cnt >= n - 1) nx = 0;
      else nx = m_cnt + 1;
      m_cnt <= nx;
      for (int k = 0; k < 2; k++) m_ch[k] <= (nx == f_off(k, n, pcnt, fol));
      m_so <= sen && !fol && (smode == 2'b00) && (nx == 0);
      m_sp <= syn;
      m_pp <= phd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(cur_req, "ch0 vs model", int'(ch[0]), int'(m_ch[0]));
      chk(cur_req, "ch1 vs model", int'(ch[1]), int'(m_ch[1]));
      chk(cur_req, "sync_o vs model", int'(so), int'(m_so));
    end
  end

  task automatic step(int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic setcfg(int n, logic [1:0] m, logic [1:0] p, logic e, logic f);
    period = CW'(n); smode = m; pcnt = p; sen = e; fol = f;
  endtask

  task automatic gap_check(string req, int expg);
    int g;
    while (!ch[0]) @(negedge clk);
    @(negedge clk);
    g = 1;
    while (!ch[1]) begin @(negedge clk); g++; end
    chk(req, "ch0 to ch1 spacing", g, expg);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cnt_a;
    void'($urandom(32'd4242));
    rst_n = 1'b0; syn = 1'b0; phd = 1'b0;
    setcfg(8, 2'b00, 2'b00, 1'b0, 1'b0);
    // R1: quiet during reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "ch_start_o in reset", int'(ch), 0);
      chk("R1", "sync_o in reset", int'(so), 0);
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R3: independent channels fire together
    cur_req = "R3";
    step(10);
    cnt_a = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); if (ch == 2'b11) cnt_a++; end
    chk("R3", "joint pulses in 32 cycles", cnt_a, 4);

    // R4: two-phase half period
    cur_req = "R4";
    setcfg(10, 2'b00, 2'b01, 1'b0, 1'b0);
    step(12);
    gap_check("R4", 5);

    // R5: three-phase leader and follower
    cur_req = "R5";
    setcfg(12, 2'b00, 2'b10, 1'b0, 1'b0);
    step(14);
    gap_check("R5", 4);
    setcfg(12, 2'b00, 2'b10, 1'b0, 1'b1);
    step(14);
    gap_check("R5", 4);

    // R6: four-phase leader and follower
    cur_req = "R6";
    setcfg(16, 2'b00, 2'b11, 1'b0, 1'b0);
    step(18);
    gap_check("R6", 8);
    setcfg(16, 2'b00, 2'b11, 1'b0, 1'b1);
    step(18);
    gap_check("R6", 8);

    // R7: external signals ignored when disabled
    cur_req = "R7";
    setcfg(8, 2'b01, 2'b00, 1'b0, 1'b0);
    cnt_a = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (ch[0]) cnt_a++;
      if (i % 3 == 0) begin syn = ~syn; phd = ~phd; end
    end
    chk("R7", "ch0 pulses in 32 cycles", cnt_a, 4);
    syn = 1'b0; phd = 1'b0;

    // R8: sync clock restarts, phase reference ignored
    cur_req = "R8";
    setcfg(20, 2'b01, 2'b00, 1'b1, 1'b0);
    step(3);
    syn = 1'b1;
    @(negedge clk);
    chk("R8", "ch0 after sync rise", int'(ch[0]), 1);
    syn = 1'b0;
    step(4);
    phd = 1'b1;
    @(negedge clk);
    chk("R8", "ch0 after ignored phdet rise", int'(ch[0]), 0);
    phd = 1'b0;

    // R9: phase reference restarts, sync ignored
    cur_req = "R9";
    setcfg(16, 2'b10, 2'b11, 1'b1, 1'b0);
    step(3);
    phd = 1'b1;
    @(negedge clk);
    chk("R9", "ch0 after phdet rise", int'(ch[0]), 1);
    phd = 1'b0;
    step(8);
    chk("R9", "ch1 at half period", int'(ch[1]), 1);
    syn = 1'b1;
    @(negedge clk);
    chk("R9", "ch0 after ignored sync rise", int'(ch[0]), 0);
    syn = 1'b0;

    // R10: follower forced to phase reference and two-controller phase count
    cur_req = "R10";
    setcfg(16, 2'b00, 2'b01, 1'b1, 1'b1);
    step(3);
    phd = 1'b1;
    step(5);
    chk("R10", "follower ch0 at quarter", int'(ch[0]), 1);
    chk("R10", "follower ch1 idle at quarter", int'(ch[1]), 0);
    chk("R11", "follower drives no sync", int'(so), 0);
    phd = 1'b0;

    // R11: leader sync output
    cur_req = "R11";
    setcfg(16, 2'b00, 2'b11, 1'b1, 1'b0);
    step(2);
    cnt_a = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); if (so) cnt_a++; end
    chk("R11", "sync pulses enabled", cnt_a, 2);
    sen = 1'b0;
    step(1);
    cnt_a = 0;
    for (int i = 0; i < 32; i++) begin @(negedge clk); if (so) cnt_a++; end
    chk("R11", "sync pulses disabled", cnt_a, 0);

    // R12: period shrink below the running count
    cur_req = "R12";
    setcfg(40, 2'b00, 2'b00, 1'b0, 1'b0);
    while (!ch[0]) @(negedge clk);
    step(20);
    period = CW'(8);
    @(negedge clk);
    chk("R12", "ch0 after period shrink", int'(ch[0]), 1);

    // R2: random configurations and reference edges
    cur_req = "R2";
    for (int s = 0; s < 25; s++) begin
      setcfg(4 + int'($urandom % 37), 2'($urandom), 2'($urandom),
             1'($urandom), 1'($urandom));
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if ($urandom % 7 == 0) syn = ~syn;
        if ($urandom % 9 == 0) phd = ~phd;
      end
    end

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule